// File: doc/BRIEF.md
# Forwarding Address Table Engine

This block decides where a frame goes in a three-port switch. It looks up the destination MAC address of each request in a small table. The result is an egress port mask. The block then removes every port that is not in forwarding state, and it removes the port the frame arrived on. A lookup request carries a MAC address and an ingress port number. The registered mask comes out one cycle later with a valid strobe.

Software manages the table through an indirect window. It fills three 32-bit data words and then writes an index to a table-control register, which either stores the words into that entry or loads that entry back into the words.

Each entry holds a type, a 48-bit MAC address and type-dependent fields. A unicast entry names one destination port. A multicast entry carries a port mask. A global control register enables the engine, starts a full-table clear and holds a VLAN-aware mode bit. Learning, aging and VLAN processing are outside this block.

Top module: `fwd_table_engine`

## Requirements
- R1: After reset, the result valid and mask are 0 and every host register reads 0 (engine disabled, all ports disabled). Every table entry is of type free.
- R2: Host register selects are: 0 global control, 1 table control, 2/3/4 data words W0/W1/W2. A table-control write with bit 31 set stores {W0,W1,W2} into the entry named by the low index bits. With bit 31 clear, the same write loads that entry into the data words, and the words read back from the next cycle on. Entry bits 31:0 map to W2 and bits 63:32 map to W1. The remaining top entry bits map to the low bits of W0, and the W0 bits above the entry read 0.
- R3: The entry type sits at bits 61:60 (0 free, 1 address, 2 VLAN, 3 VLAN plus address). The MAC sits at bits 47:0, with the first byte at 47:40. Only types 1 and 3 take part in a lookup, and among matching entries the lowest index wins.
- R4: An entry with bit 40 clear is unicast. Bits 67:66 give the destination port, and the raw mask has that port's bit alone set. Setting bit 65 (blocked) gives an all-zero mask.
- R5: An entry with bit 40 set is multicast, and its raw mask is the port mask stored at bits 68:66.
- R6: Port p has a control register at select 5+p, whose bits 1:0 hold its state (0 disabled, 1 blocking, 2 learning, 3 forwarding). The output mask is the raw mask ANDed with the ports in state 3, with the ingress port's bit cleared.
- R7: The output mask is all zero when no entry matches, and also when global-control bit 31 (enable) is 0.
- R8: The result valid rises exactly one cycle after a lookup request, and it carries that request's mask. The valid and mask are 0 in cycles without a request.
- R9: Writing global-control bit 30 clears the table. Every entry's type becomes free at one entry per cycle, and the other entry bits are kept. Bit 30 reads 1 while the clear is running and then returns to 0 by itself. Lookups during the clear give a zero mask, and table stores during the clear are ignored.
- R10: Global-control bit 2 (VLAN-aware) can be written and read back, and it does not change lookup results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 3 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_sel (combinational) |
| req_valid | input | 1 | Lookup request strobe |
| req_mac | input | 48 | Destination MAC address to resolve |
| req_port | input | 2 | Ingress port number |
| res_valid | output | 1 | Lookup result strobe |
| res_mask | output | 3 | Egress port mask |

## Verification
Assertions check several rules on every cycle:
- the result strobe follows the request by one cycle;
- no mask ever names the ingress port or a port that is not forwarding;
- a disabled or clearing engine yields an empty mask;
- a unicast result has at most one bit set;
- the clear walk advances one entry per cycle and then stops;
- a table load lands in the data words.

Only the directed scenarios can show the following:
- the exact word mapping of entries;
- which entry wins among duplicates and the effect of the entry type;
- the difference between blocked unicast and multicast entries;
- that the clear keeps MAC bits;
- that stores during a clear are dropped;
- that the VLAN bit has no effect.

// File: rtl/fwd_tbl_pkg.sv
package fwd_tbl_pkg;

  typedef enum logic [1:0] {
    KIND_FREE      = 2'd0,
    KIND_ADDR      = 2'd1,
    KIND_VLAN      = 2'd2,
    KIND_VLAN_ADDR = 2'd3
  } entry_kind_e;

  typedef enum logic [1:0] {
    PST_OFF   = 2'd0,
    PST_BLOCK = 2'd1,
    PST_LEARN = 2'd2,
    PST_FWD   = 2'd3
  } port_state_e;

  // host register selects
  localparam int SEL_GCTL = 0;
  localparam int SEL_TCTL = 1;
  localparam int SEL_W0   = 2;
  localparam int SEL_W1   = 3;
  localparam int SEL_W2   = 4;
  localparam int SEL_PC0  = 5;

  // entry field positions
  localparam int MAC_W        = 48;
  localparam int GROUP_BIT    = 40;
  localparam int KIND_LSB     = 60;
  localparam int BLOCK_BIT    = 65;
  localparam int DEST_LSB     = 66;

  // global control bit positions
  localparam int GC_ENABLE = 31;
  localparam int GC_CLEAR  = 30;
  localparam int GC_VLAN   = 2;
  localparam int TC_STORE  = 31;

endpackage

// File: rtl/fwd_tbl_store.sv
module fwd_tbl_store
  import fwd_tbl_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ENTRY_W = 69,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr_start,
  input  logic                              st_en,
  input  logic [IDX_W-1:0]                  st_idx,
  input  logic [ENTRY_W-1:0]                st_data,
  output logic [ENTRIES-1:0][ENTRY_W-1:0]   tbl,
  output logic                              clr_busy
);

  logic [IDX_W-1:0] clr_idx;
  wire clr_last = (clr_idx == IDX_W'(ENTRIES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl      <= '0;
      clr_busy <= 1'b0;
      clr_idx  <= '0;
    end else if (clr_busy) begin
      tbl[clr_idx][KIND_LSB +: 2] <= KIND_FREE;
      if (clr_last) begin
        clr_busy <= 1'b0;
        clr_idx  <= '0;
      end else begin
        clr_idx <= clr_idx + 1'b1;
      end
    end else if (clr_start) begin
      clr_busy <= 1'b1;
      clr_idx  <= '0;
    end else if (st_en) begin
      tbl[st_idx] <= st_data;
    end
  end

  // clear walks one entry per cycle (R9)
  assert_clear_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy && !clr_last |=> clr_busy && (clr_idx == $past(clr_idx) + 1'b1));
  assert_clear_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy && clr_last |=> !clr_busy);

endmodule

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_tbl_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ENTRY_W = 69,
  parameter int PORTS   = 3,
  localparam int PORT_W = $clog2(PORTS)
) (
  input  logic [ENTRIES-1:0][ENTRY_W-1:0] tbl,
  input  logic [MAC_W-1:0]                mac,
  output logic                            hit,
  output logic                            hit_mcast,
  output logic [PORTS-1:0]                raw_mask
);

  function automatic logic entry_matches(input logic [ENTRY_W-1:0] e,
                                         input logic [MAC_W-1:0] m);
    logic [1:0] k;
    k = e[KIND_LSB +: 2];
    return ((k == KIND_ADDR) || (k == KIND_VLAN_ADDR)) && (e[MAC_W-1:0] == m);
  endfunction

  function automatic logic [PORTS-1:0] mask_of(input logic [ENTRY_W-1:0] e);
    logic [PORTS-1:0]  m;
    logic [PORT_W-1:0] dest;
    m = '0;
    dest = e[DEST_LSB +: PORT_W];
    if (e[GROUP_BIT]) begin
      m = e[DEST_LSB +: PORTS];
    end else if (!e[BLOCK_BIT]) begin
      for (int p = 0; p < PORTS; p++)
        if (int'(dest) == p) m[p] = 1'b1;
    end
    return m;
  endfunction

  logic [ENTRY_W-1:0] sel_entry;

  always_comb begin
    hit       = 1'b0;
    sel_entry = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (entry_matches(tbl[i], mac)) begin
        hit       = 1'b1;
        sel_entry = tbl[i];
      end
    end
    hit_mcast = hit && sel_entry[GROUP_BIT];
    raw_mask  = hit ? mask_of(sel_entry) : '0;
  end

endmodule

// File: rtl/fwd_filter.sv
module fwd_filter
  import fwd_tbl_pkg::*;
#(
  parameter int PORTS   = 3,
  localparam int PORT_W = $clog2(PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic [PORTS-1:0]  raw_mask,
  input  logic              hit_mcast,
  input  logic [PORTS-1:0]  fwd_ports,
  input  logic              allow,
  output logic              res_valid,
  output logic [PORTS-1:0]  res_mask
);

  function automatic logic [PORTS-1:0] port_bit(input logic [PORT_W-1:0] p);
    logic [PORTS-1:0] b;
    b = '0;
    for (int i = 0; i < PORTS; i++)
      if (int'(p) == i) b[i] = 1'b1;
    return b;
  endfunction

  wire [PORTS-1:0] ingress_bit = port_bit(req_port);
  wire [PORTS-1:0] next_mask   = allow ? (raw_mask & fwd_ports & ~ingress_bit) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_mask  <= '0;
    end else begin
      res_valid <= req_valid;
      res_mask  <= req_valid ? next_mask : '0;
    end
  end

  assert_fwd_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_mask & ~$past(fwd_ports)) == '0));
  assert_no_ingress_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_mask & $past(ingress_bit)) == '0));
  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !$past(allow) |-> res_mask == '0);
  assert_ucast_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !$past(hit_mcast) |-> $onehot0(res_mask));
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && res_mask == '0);

endmodule

// File: rtl/fwd_table_engine.sv
module fwd_table_engine
  import fwd_tbl_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PORTS   = 3,
  localparam int PORT_W  = $clog2(PORTS),
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int ENTRY_W = DEST_LSB + ((PORTS > PORT_W) ? PORTS : PORT_W),
  localparam int TOP_W   = ENTRY_W - 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [2:0]        host_sel,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              req_valid,
  input  logic [MAC_W-1:0]  req_mac,
  input  logic [PORT_W-1:0] req_port,
  output logic              res_valid,
  output logic [PORTS-1:0]  res_mask
);

  logic        ctrl_enable, ctrl_vlan;
  logic [31:0] w0, w1, w2;
  logic [PORTS-1:0][1:0] pst;
  logic [PORTS-1:0]      fwd_ports;

  logic [ENTRIES-1:0][ENTRY_W-1:0] tbl;
  logic clr_busy, hit, hit_mcast;
  logic [PORTS-1:0] raw_mask;

  // decoded host events
  wire gctl_wr  = host_wr && (host_sel == 3'(SEL_GCTL));
  wire tctl_wr  = host_wr && (host_sel == 3'(SEL_TCTL));
  wire st_pulse = tctl_wr && host_wdata[TC_STORE];
  wire ld_pulse = tctl_wr && !host_wdata[TC_STORE];
  wire clr_req  = gctl_wr && host_wdata[GC_CLEAR];
  wire [IDX_W-1:0] acc_idx = host_wdata[IDX_W-1:0];
  wire [95:0] win_packed   = {w0, w1, w2};
  wire [95:0] ld_wide      = {{(96 - ENTRY_W){1'b0}}, tbl[acc_idx]};
  wire allow               = ctrl_enable && !clr_busy;

  logic unused_wdata;
  assign unused_wdata = ^{host_wdata[29:IDX_W], host_wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_enable <= 1'b0;
      ctrl_vlan   <= 1'b0;
      w0 <= '0;
      w1 <= '0;
      w2 <= '0;
    end else if (host_wr) begin
      if (gctl_wr) begin
        ctrl_enable <= host_wdata[GC_ENABLE];
        ctrl_vlan   <= host_wdata[GC_VLAN];
      end
      if (ld_pulse) begin
        w0 <= ld_wide[95:64];
        w1 <= ld_wide[63:32];
        w2 <= ld_wide[31:0];
      end
      if (host_sel == 3'(SEL_W0)) w0 <= host_wdata;
      if (host_sel == 3'(SEL_W1)) w1 <= host_wdata;
      if (host_sel == 3'(SEL_W2)) w2 <= host_wdata;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pst[p] <= PST_OFF;
      else if (host_wr && (host_sel == 3'(SEL_PC0 + p)))
        pst[p] <= host_wdata[1:0];
    end
    assign fwd_ports[p] = (pst[p] == PST_FWD);
  end

  always_comb begin
    host_rdata = '0;
    case (int'(host_sel))
      SEL_GCTL: begin
        host_rdata[GC_ENABLE] = ctrl_enable;
        host_rdata[GC_CLEAR]  = clr_busy;
        host_rdata[GC_VLAN]   = ctrl_vlan;
      end
      SEL_W0: host_rdata = {{(32 - TOP_W){1'b0}}, w0[TOP_W-1:0]};
      SEL_W1: host_rdata = w1;
      SEL_W2: host_rdata = w2;
      default: begin
        for (int p = 0; p < PORTS; p++)
          if (int'(host_sel) == SEL_PC0 + p) host_rdata[1:0] = pst[p];
      end
    endcase
  end

  fwd_tbl_store #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_start(clr_req),
    .st_en    (st_pulse),
    .st_idx   (acc_idx),
    .st_data  (win_packed[ENTRY_W-1:0]),
    .tbl      (tbl),
    .clr_busy (clr_busy)
  );

  fwd_match #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W), .PORTS(PORTS)) u_match (
    .tbl      (tbl),
    .mac      (req_mac),
    .hit      (hit),
    .hit_mcast(hit_mcast),
    .raw_mask (raw_mask)
  );

  fwd_filter #(.PORTS(PORTS)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_port (req_port),
    .raw_mask (raw_mask),
    .hit_mcast(hit_mcast),
    .fwd_ports(fwd_ports),
    .allow    (allow),
    .res_valid(res_valid),
    .res_mask (res_mask)
  );

  // a load lands in the data words on the next cycle (R2)
  assert_load_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pulse |=> (w2 == $past(ld_wide[31:0])) && (w1 == $past(ld_wide[63:32])));
  // a miss never produces a port (R7)
  assert_miss_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hit |=> res_mask == '0);

endmodule

// File: tb/fwd_table_engine_test.sv
module fwd_table_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_sel = 3'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        req_valid = 1'b0;
  logic [47:0] req_mac = '0;
  logic [1:0]  req_port = '0;
  logic        res_valid;
  logic [2:0]  res_mask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fwd_table_engine uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .req_valid(req_valid),
    .req_mac(req_mac), .req_port(req_port), .res_valid(res_valid), .res_mask(res_mask)
  );

  localparam logic [47:0] MAC_A = 48'h0010_2030_4050;
  localparam logic [47:0] MAC_B = 48'h0A0B_0C0D_0E0F;
  localparam logic [47:0] MAC_C = 48'h0100_5E00_0001;
  localparam logic [47:0] MAC_D = 48'h0022_3344_5566;
  localparam logic [47:0] MAC_E = 48'h0066_7788_99AA;
  localparam logic [47:0] MAC_F = 48'h00BB_CCDD_EEFF;
  localparam logic [47:0] MAC_G = 48'h0012_1212_1212;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = 3'(sel); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input int sel, output logic [31:0] d);
    host_sel = 3'(sel);
    #0.5;
    d = host_rdata;
  endtask

  function automatic logic [95:0] uc(input logic [47:0] mac, input logic [1:0] port,
                                     input logic blk, input logic [1:0] kind);
    logic [95:0] e = '0;
    e[47:0] = mac; e[61:60] = kind; e[65] = blk; e[67:66] = port;
    return e;
  endfunction

  function automatic logic [95:0] mc(input logic [47:0] mac, input logic [2:0] mask);
    logic [95:0] e = '0;
    e[47:0] = mac; e[61:60] = 2'd1; e[63:62] = 2'd3; e[68:66] = mask;
    return e;
  endfunction

  task automatic put(input int idx, input logic [95:0] e);
    wr(2, e[95:64]); wr(3, e[63:32]); wr(4, e[31:0]);
    wr(1, 32'h8000_0000 | idx);
  endtask

  task automatic look(input string req, input logic [47:0] mac, input logic [1:0] port,
                      input logic [2:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_mac = mac; req_port = port;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, "result valid", 32'(res_valid), 32'd1);
    check(req, "result mask", 32'(res_mask), 32'(exp));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1", "valid after reset", 32'(res_valid), 0);
    check("R1", "mask after reset", 32'(res_mask), 0);
    rd(0, d); check("R1", "global control", d, 0);
    rd(4, d); check("R1", "word W2", d, 0);
    rd(5, d); check("R1", "port0 state", d, 0);
  endtask

  task automatic t_window;
    logic [31:0] d;
    wr(2, 32'hFFFF_FFFF); wr(3, 32'h0123_4567); wr(4, 32'h89AB_CDEF);
    wr(1, 32'h8000_0009);
    wr(2, 0); wr(3, 0); wr(4, 0);
    wr(1, 32'h0000_0009);
    rd(2, d); check("R2", "W0 top bits", d, 32'h0000_001F);
    rd(3, d); check("R2", "W1 bits 63:32", d, 32'h0123_4567);
    rd(4, d); check("R2", "W2 bits 31:0", d, 32'h89AB_CDEF);
  endtask

  task automatic t_ucast;
    put(1, uc(MAC_A, 2'd2, 1'b0, 2'd1));
    put(10, uc(MAC_B, 2'd1, 1'b1, 2'd1));
    look("R4", MAC_A, 2'd0, 3'b100);
    look("R6", MAC_A, 2'd2, 3'b000);
    look("R4", MAC_B, 2'd0, 3'b000);
  endtask

  task automatic t_mcast;
    put(2, mc(MAC_C, 3'b111));
    look("R5", MAC_C, 2'd1, 3'b101);
    wr(5, 32'd2);
    look("R6", MAC_C, 2'd1, 3'b100);
    wr(5, 32'd3);
    look("R5", MAC_C, 2'd3, 3'b111);
  endtask

  task automatic t_order;
    put(3, uc(MAC_D, 2'd1, 1'b0, 2'd0));
    put(4, uc(MAC_D, 2'd0, 1'b0, 2'd1));
    look("R3", MAC_D, 2'd2, 3'b001);
    put(6, uc(MAC_E, 2'd0, 1'b0, 2'd2));
    look("R3", MAC_E, 2'd2, 3'b000);
    put(7, uc(MAC_F, 2'd1, 1'b0, 2'd1));
    put(8, uc(MAC_F, 2'd2, 1'b0, 2'd1));
    look("R3", MAC_F, 2'd0, 3'b010);
    put(11, uc(MAC_G, 2'd0, 1'b0, 2'd3));
    look("R3", MAC_G, 2'd1, 3'b001);
  endtask

  task automatic t_off;
    look("R7", 48'h00DE_ADBE_EF00, 2'd0, 3'b000);
    wr(0, 32'h0000_0000);
    look("R7", MAC_A, 2'd0, 3'b000);
    wr(0, 32'h8000_0000);
  endtask

  task automatic t_latency;
    look("R8", MAC_A, 2'd1, 3'b100);
    @(negedge clk);
    check("R8", "valid idle", 32'(res_valid), 0);
    check("R8", "mask idle", 32'(res_mask), 0);
  endtask

  task automatic t_vlan;
    logic [31:0] d;
    wr(0, 32'h8000_0004);
    rd(0, d); check("R10", "vlan bit readback", d, 32'h8000_0004);
    look("R10", MAC_A, 2'd0, 3'b100);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(0, 32'hC000_0000);
    rd(0, d); check("R9", "busy flag", d, 32'hC000_0000);
    put(1, uc(MAC_B, 2'd0, 1'b0, 2'd1));
    look("R9", MAC_C, 2'd1, 3'b000);
    repeat (20) @(negedge clk);
    rd(0, d); check("R9", "busy self-clears", d, 32'h8000_0000);
    look("R9", MAC_A, 2'd0, 3'b000);
    wr(1, 32'h0000_0001);
    rd(4, d); check("R9", "mac kept, store ignored", d, MAC_A[31:0]);
    rd(3, d); check("R9", "type freed", d, {16'h0, MAC_A[47:32]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    wr(0, 32'h8000_0000);
    wr(5, 32'd3); wr(6, 32'd3); wr(7, 32'd3);
    t_ucast();
    t_mcast();
    t_order();
    t_off();
    t_latency();
    t_vlan();
    t_clear();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule